// File: doc/BRIEF.md
# Decode-Stage Pipeline Stall Detector

This block decides, in the same cycle, whether the instruction now in decode must wait one cycle before it moves into execute. It serves a five-stage in-order pipeline whose branches and jumps are resolved in decode. A result still in the execute stage cannot yet be forwarded into decode, so two hazards are possible. The first is a load in execute whose data is not ready for any consumer. The second is any register-writing instruction in execute whose result a decode-stage branch or jump needs for its comparison or target.

When the block raises its stall request, the surrounding pipeline holds the program counter and the fetch/decode register in place. It also clears every control field entering the decode/execute register, which inserts a bubble. The block holds no state. Its output is a pure function of the execute-stage destination index, the execute-stage load and write-back flags, the decode instruction's two source indices and the decode control-transfer flag.

Top module: `hazard_stall_unit`

## Requirements
- R1: With the execute-stage load flag set and a nonzero execute destination equal to the decode first-source index, the stall request is 1.
- R2: With the execute-stage load flag set and a nonzero execute destination equal to the decode second-source index, the stall request is 1.
- R3: With the decode control-transfer flag and the execute write-back flag both set, a nonzero execute destination equal to either decode source index gives a stall request of 1.
- R4: An execute destination index of 0 never raises the stall request, whatever the flags and source indices are.
- R5: When the execute destination equals neither decode source index, the stall request is 0.
- R6: Without the load flag, a matching nonzero destination stalls only if both the control-transfer and the write-back flags are set. A write-back alone, or a control transfer alone, gives 0.
- R7: The stall request follows its inputs within the same cycle, with no register in the path. With every input at 0 it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_load_i | input | 1 | Execute-stage instruction reads memory |
| ex_dst_idx_i | input | IDX_W | Execute-stage destination register index |
| dec_rs1_idx_i | input | IDX_W | Decode instruction first source index |
| dec_rs2_idx_i | input | IDX_W | Decode instruction second source index |
| dec_ctrl_xfer_i | input | 1 | Decode instruction is a branch or jump |
| ex_reg_wr_i | input | 1 | Execute-stage instruction writes a register |
| bubble_o | output | 1 | Stall request: hold PC and fetch/decode, clear decode/execute controls |

## Verification
Every result is due in the same cycle as its stimulus, with zero registers in between. The bench therefore applies each input vector on a falling clock edge and compares `bubble_o` 2 ns later, before the next rising edge. The sweep covers every combination of destination, both source indices and the three flags, with a 3-bit index width. This reaches each index match pattern, including destination 0 against every source. The expected value comes from the hazard equations written in the bench, and each miss is attributed to the requirement that governs that vector.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  // number of source operands compared per decode instruction
  localparam int unsigned NUM_SRC = 2;

  // why the pipeline must wait
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_LOAD = 2'd1,
    CAUSE_CTRL = 2'd2
  } hzd_cause_e;

endpackage

// File: rtl/hzd_src_match.sv
module hzd_src_match #(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] dst_idx,
  input  logic [IDX_W-1:0] src_idx,
  output logic             hit
);

  // plain index equality; the x0 filter is applied once at the top
  always_comb begin
    hit = (dst_idx == src_idx);
  end

endmodule

// File: rtl/hzd_cause_sel.sv
module hzd_cause_sel
  import hzd_pkg::*;
(
  input  logic       dst_live,
  input  logic       any_hit,
  input  logic       ex_load,
  input  logic       ex_reg_wr,
  input  logic       dec_ctrl_xfer,
  output hzd_cause_e cause
);

  always_comb begin
    cause = CAUSE_NONE;
    if (dst_live && any_hit) begin
      // a load result is never forwardable in time
      if (ex_load) begin
        cause = CAUSE_LOAD;
      // decode-resolved transfer needs an operand still in the ALU
      end else if (dec_ctrl_xfer && ex_reg_wr) begin
        cause = CAUSE_CTRL;
      end
    end
  end

endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit
  import hzd_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic             ex_load_i,
  input  logic [IDX_W-1:0] ex_dst_idx_i,
  input  logic [IDX_W-1:0] dec_rs1_idx_i,
  input  logic [IDX_W-1:0] dec_rs2_idx_i,
  input  logic             dec_ctrl_xfer_i,
  input  logic             ex_reg_wr_i,
  output logic             bubble_o
);

  logic [NUM_SRC-1:0][IDX_W-1:0] src_idx;
  logic [NUM_SRC-1:0]            src_hit;
  logic                          dst_live;
  hzd_cause_e                    cause;

  assign src_idx[0] = dec_rs1_idx_i;
  assign src_idx[1] = dec_rs2_idx_i;

  // register 0 is hard-wired, so it never carries a pending result
  assign dst_live = (ex_dst_idx_i != '0);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    hzd_src_match #(.IDX_W(IDX_W)) u_match (
      .dst_idx (ex_dst_idx_i),
      .src_idx (src_idx[g]),
      .hit     (src_hit[g])
    );
  end

  hzd_cause_sel u_cause (
    .dst_live      (dst_live),
    .any_hit       (|src_hit),
    .ex_load       (ex_load_i),
    .ex_reg_wr     (ex_reg_wr_i),
    .dec_ctrl_xfer (dec_ctrl_xfer_i),
    .cause         (cause)
  );

  assign bubble_o = (cause != CAUSE_NONE);

endmodule

// File: rtl/hazard_stall_unit_chk.sv
module hazard_stall_unit_chk #(
  parameter int unsigned IDX_W = 5
) (
  input logic             ex_load_i,
  input logic [IDX_W-1:0] ex_dst_idx_i,
  input logic [IDX_W-1:0] dec_rs1_idx_i,
  input logic [IDX_W-1:0] dec_rs2_idx_i,
  input logic             dec_ctrl_xfer_i,
  input logic             ex_reg_wr_i,
  input logic             bubble_o
);

  always_comb begin
    // R4
    x0_never_stalls_chk: assert (!(bubble_o && ex_dst_idx_i == '0))
      else $error("stall raised for destination 0");
    // R5
    stall_needs_match_chk: assert (!bubble_o ||
        ex_dst_idx_i == dec_rs1_idx_i || ex_dst_idx_i == dec_rs2_idx_i)
      else $error("stall raised without index match");
    // R6
    stall_needs_cause_chk: assert (!bubble_o || ex_load_i ||
        (dec_ctrl_xfer_i && ex_reg_wr_i))
      else $error("stall raised without load or control-transfer cause");
    // R1
    load_rs1_stall_chk: assert (!(ex_load_i && ex_dst_idx_i != '0 &&
        ex_dst_idx_i == dec_rs1_idx_i) || bubble_o)
      else $error("missed load-use stall on first source");
    // R2
    load_rs2_stall_chk: assert (!(ex_load_i && ex_dst_idx_i != '0 &&
        ex_dst_idx_i == dec_rs2_idx_i) || bubble_o)
      else $error("missed load-use stall on second source");
  end

endmodule

bind hazard_stall_unit hazard_stall_unit_chk #(.IDX_W(IDX_W)) u_chk (
  .ex_load_i       (ex_load_i),
  .ex_dst_idx_i    (ex_dst_idx_i),
  .dec_rs1_idx_i   (dec_rs1_idx_i),
  .dec_rs2_idx_i   (dec_rs2_idx_i),
  .dec_ctrl_xfer_i (dec_ctrl_xfer_i),
  .ex_reg_wr_i     (ex_reg_wr_i),
  .bubble_o        (bubble_o)
);

// File: tb/hazard_stall_unit_tb.sv
`timescale 1ns/1ps
module hazard_stall_unit_tb;

  localparam int unsigned IDX_W = 3;
  localparam int unsigned NIDX  = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ex_load, dec_xfer, ex_wr;
  logic [IDX_W-1:0] dst, rs1, rs2;
  logic             bubble;
  int               checks = 0;
  int               errors = 0;
  bit               done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  hazard_stall_unit #(.IDX_W(IDX_W)) u_dut (
    .ex_load_i       (ex_load),
    .ex_dst_idx_i    (dst),
    .dec_rs1_idx_i   (rs1),
    .dec_rs2_idx_i   (rs2),
    .dec_ctrl_xfer_i (dec_xfer),
    .ex_reg_wr_i     (ex_wr),
    .bubble_o        (bubble)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (bubble !== exp) begin
      errors++;
      $display("FAIL %s: dst=%0d rs1=%0d rs2=%0d load=%0b xfer=%0b wr=%0b actual=%0b expected=%0b",
               req, dst, rs1, rs2, ex_load, dec_xfer, ex_wr, bubble, exp);
    end
  endtask

  initial begin
    ex_load = 1'b0; dec_xfer = 1'b0; ex_wr = 1'b0;
    dst = '0; rs1 = '0; rs2 = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(1'b0, "R7"); // all-zero inputs, no stall

    for (int f = 0; f < 8; f++) begin
      for (int d = 0; d < NIDX; d++) begin
        for (int a = 0; a < NIDX; a++) begin
          for (int b = 0; b < NIDX; b++) begin
            logic  m1, m2, exp;
            string req;
            @(negedge clk);
            ex_load  = f[0];
            dec_xfer = f[1];
            ex_wr    = f[2];
            dst = IDX_W'(d); rs1 = IDX_W'(a); rs2 = IDX_W'(b);
            m1  = (d != 0) && (d == a);
            m2  = (d != 0) && (d == b);
            exp = (m1 || m2) && (f[0] || (f[1] && f[2]));
            if (d == 0)                 req = "R4";
            else if (d != a && d != b)  req = "R5";
            else if (f[0] && m1)        req = "R1";
            else if (f[0])              req = "R2";
            else if (f[1] && f[2])      req = "R3";
            else                        req = "R6";
            #2; // same-cycle result, sampled before the next rising edge (R7)
            check(exp, req);
          end
        end
      end
    end

    // combinational follow: flip one input within a cycle (R7)
    @(negedge clk);
    ex_load = 1'b1; dec_xfer = 1'b0; ex_wr = 1'b1;
    dst = 3'd5; rs1 = 3'd5; rs2 = 3'd1;
    #1; check(1'b1, "R7");
    rs1 = 3'd2;
    #1; check(1'b0, "R7");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8.0 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule